// File: doc/BRIEF.md
# YCbCr to RGB Converter with Chroma Upsampling

This block turns a stream of pixels coded as luma plus two chroma components into 8-bit red, green and blue. The chroma arrives 4:2:0 subsampled: one Cb and one Cr sample cover a 2×2 group of luma pixels. The block does not simply repeat that sample over the group. It interpolates a chroma value for every pixel from the surrounding chroma samples, and then applies a fixed-coefficient colour matrix.

Each input cycle carries one luma value on `inY`. For each chroma plane it also carries the chroma sample that owns the pixel's 2×2 group, plus that sample's right, lower and lower-right neighbours. The parity of the pixel's column and row selects the interpolation. Two edge flags tell the block that the right or lower neighbour lies outside the picture. The upstream scan logic keeps the chroma rows and supplies the neighbours. The block itself holds no line storage and accepts one pixel per cycle.

Top module: `ycc_to_rgb`

## Requirements
- R1: Red is `clamp((Y·4096 + 5743·(Cr−128) + 2048) >> 12)`, where Cr is the interpolated Cr and `>>` is an arithmetic (floor) shift.
- R2: Green is `clamp((Y·4096 − 1410·(Cb−128) − 2925·(Cr−128) + 2048) >> 12)`. When both interpolated chroma values are 128, the three outputs are equal.
- R3: Blue is `clamp((Y·4096 + 7258·(Cb−128) + 2048) >> 12)`.
- R4: Every colour result is clamped to 0..255. Negative results give 0 and results above 255 give 255.
- R5: When `pixXOdd`=0 and `pixYOdd`=0, the interpolated chroma equals the near sample and ignores the neighbour inputs.
- R6: When `pixXOdd`=1 and `pixYOdd`=0, the chroma is `(near + right + 1) >> 1`.
- R7: When `pixXOdd`=0 and `pixYOdd`=1, the chroma is `(near + below + 1) >> 1`.
- R8: When both parity inputs are 1, the chroma is `(near + right + below + diag + 2) >> 2`.
- R9: With `atRightEdge`=1, the right input is replaced by near and the diagonal input by the (possibly replaced) below value. With `atBottomEdge`=1, the below input is replaced by near and the diagonal input by the (possibly replaced) right value. With both flags set, all neighbours become near.
- R10: A pixel accepted with `inValid`=1 on a clock edge appears with `outValid`=1 exactly three rising edges later. One pixel is accepted per cycle, and `outValid` is 0 when no pixel was accepted three edges earlier.
- R11: While `rstN`=0, `outValid` and all colour outputs are 0. While `outValid` is 0, the colour outputs keep their last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Pixel present on the inputs |
| inY | input | 8 | Luma |
| pixXOdd | input | 1 | Pixel sits in an odd column of its 2×2 chroma group |
| pixYOdd | input | 1 | Pixel sits in an odd row of its 2×2 chroma group |
| atRightEdge | input | 1 | Right chroma neighbour is outside the picture |
| atBottomEdge | input | 1 | Lower chroma neighbour is outside the picture |
| cbNear | input | 8 | Cb sample owning the pixel's group |
| cbRight | input | 8 | Cb sample to the right |
| cbBelow | input | 8 | Cb sample below |
| cbDiag | input | 8 | Cb sample below and to the right |
| crNear | input | 8 | Cr sample owning the pixel's group |
| crRight | input | 8 | Cr sample to the right |
| crBelow | input | 8 | Cr sample below |
| crDiag | input | 8 | Cr sample below and to the right |
| outValid | output | 1 | Colour outputs carry a new pixel |
| outR | output | 8 | Red |
| outG | output | 8 | Green |
| outB | output | 8 | Blue |

## Verification
The cases that are hardest to reach are the corner pixels. There, both edge flags and both parity bits interact, and a wrong substitution of the diagonal neighbour changes the result by only one or two codes. Random data rarely pins this down. The stimulus therefore opens with directed pixels that place an extreme value (250) in exactly the neighbour that must be ignored. The four-way average then shifts visibly if that neighbour leaks through. After that, random traffic with about one pixel in ten at an edge, plus idle gaps, covers the hold behaviour and the rounding of negative products.

// File: rtl/ycc_pkg.sv
package ycc_pkg;
  localparam int PIX_W   = 8;
  localparam int FRAC_W  = 12;
  localparam int LATENCY = 3;

  typedef struct packed {
    logic ldUp;
    logic ldMul;
    logic ldOut;
  } stageStrobe_t;
endpackage

// File: rtl/ycc_chroma_interp.sv
module ycc_chroma_interp #(
  parameter int W = 8
) (
  input  logic [W-1:0] near,
  input  logic [W-1:0] right,
  input  logic [W-1:0] below,
  input  logic [W-1:0] diag,
  input  logic         xOdd,
  input  logic         yOdd,
  input  logic         edgeR,
  input  logic         edgeB,
  output logic [W-1:0] value
);
  logic [W-1:0] rSel, bSel, dSel;
  logic [W+1:0] sum2h, sum2v, sum4;

  always_comb begin
    rSel = edgeR ? near : right;
    bSel = edgeB ? near : below;
    if (edgeR)      dSel = bSel;
    else if (edgeB) dSel = rSel;
    else            dSel = diag;
    sum2h = {2'b00, near} + {2'b00, rSel} + (W+2)'(1);
    sum2v = {2'b00, near} + {2'b00, bSel} + (W+2)'(1);
    sum4  = {2'b00, near} + {2'b00, rSel} + {2'b00, bSel} + {2'b00, dSel} + (W+2)'(2);
    unique case ({yOdd, xOdd})
      2'b00:   value = near;
      2'b01:   value = sum2h[W:1];
      2'b10:   value = sum2v[W:1];
      default: value = sum4[W+1:2];
    endcase
  end
endmodule

// File: rtl/ycc_ctrl.sv
module ycc_ctrl
  import ycc_pkg::*;
#(
  parameter int LAT = LATENCY
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  output stageStrobe_t strobe,
  output logic         outValid
);
  logic [LAT-1:0] vldPipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) vldPipe <= '0;
    else       vldPipe <= {vldPipe[LAT-2:0], inValid};
  end

  always_comb begin
    strobe.ldUp  = inValid;
    strobe.ldMul = vldPipe[0];
    strobe.ldOut = vldPipe[1];
  end

  assign outValid = vldPipe[LAT-1];
endmodule

// File: rtl/ycc_datapath.sv
module ycc_datapath
  import ycc_pkg::*;
#(
  parameter int PW = PIX_W,
  parameter int FW = FRAC_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  stageStrobe_t  strobe,
  input  logic [PW-1:0] inY,
  input  logic          pixXOdd,
  input  logic          pixYOdd,
  input  logic          atRightEdge,
  input  logic          atBottomEdge,
  input  logic [PW-1:0] cbNear,
  input  logic [PW-1:0] cbRight,
  input  logic [PW-1:0] cbBelow,
  input  logic [PW-1:0] cbDiag,
  input  logic [PW-1:0] crNear,
  input  logic [PW-1:0] crRight,
  input  logic [PW-1:0] crBelow,
  input  logic [PW-1:0] crDiag,
  output logic [PW-1:0] outR,
  output logic [PW-1:0] outG,
  output logic [PW-1:0] outB
);
  localparam int CW  = FW + 2;
  localparam int OW  = PW + 2;
  localparam int ACC = CW + OW;
  localparam int SW  = ACC + 1;
  localparam logic signed [CW-1:0] K_RCR = CW'((1402 * (1 << FW) + 500) / 1000);
  localparam logic signed [CW-1:0] K_GCB = CW'((34414 * (1 << FW) + 50000) / 100000);
  localparam logic signed [CW-1:0] K_GCR = CW'((71414 * (1 << FW) + 50000) / 100000);
  localparam logic signed [CW-1:0] K_BCB = CW'((1772 * (1 << FW) + 500) / 1000);
  localparam logic signed [OW-1:0] MID   = OW'(1 << (PW - 1));
  localparam logic signed [SW-1:0] HALF  = SW'(1 << (FW - 1));
  localparam logic signed [SW-1:0] TOP   = SW'((1 << PW) - 1);

  logic [PW-1:0] cbUp, crUp;
  logic [PW-1:0] yS1, cbS1, crS1, yS2;
  logic signed [OW-1:0] cbOff, crOff;
  logic signed [ACC-1:0] rMul, gMul, bMul, rTerm, gTerm, bTerm;

  ycc_chroma_interp #(.W(PW)) u_cbInterp (
    .near(cbNear), .right(cbRight), .below(cbBelow), .diag(cbDiag),
    .xOdd(pixXOdd), .yOdd(pixYOdd), .edgeR(atRightEdge), .edgeB(atBottomEdge),
    .value(cbUp)
  );

  ycc_chroma_interp #(.W(PW)) u_crInterp (
    .near(crNear), .right(crRight), .below(crBelow), .diag(crDiag),
    .xOdd(pixXOdd), .yOdd(pixYOdd), .edgeR(atRightEdge), .edgeB(atBottomEdge),
    .value(crUp)
  );

  always_comb begin
    cbOff = $signed({2'b00, cbS1}) - MID;
    crOff = $signed({2'b00, crS1}) - MID;
    rMul  = ACC'(K_RCR * crOff);
    bMul  = ACC'(K_BCB * cbOff);
    gMul  = -ACC'(K_GCB * cbOff) - ACC'(K_GCR * crOff);
  end

  function automatic logic [PW-1:0] finish(input logic [PW-1:0] y,
                                           input logic signed [ACC-1:0] term);
    logic signed [SW-1:0] s;
    s = $signed({{(SW-PW-FW){1'b0}}, y, {FW{1'b0}}}) + SW'(term) + HALF;
    s = s >>> FW;
    if (s < 0)        return '0;
    else if (s > TOP) return '1;
    else              return s[PW-1:0];
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      yS1 <= '0; cbS1 <= '0; crS1 <= '0;
      yS2 <= '0; rTerm <= '0; gTerm <= '0; bTerm <= '0;
      outR <= '0; outG <= '0; outB <= '0;
    end else begin
      if (strobe.ldUp) begin
        yS1  <= inY;
        cbS1 <= cbUp;
        crS1 <= crUp;
      end
      if (strobe.ldMul) begin
        yS2   <= yS1;
        rTerm <= rMul;
        gTerm <= gMul;
        bTerm <= bMul;
      end
      if (strobe.ldOut) begin
        outR <= finish(yS2, rTerm);
        outG <= finish(yS2, gTerm);
        outB <= finish(yS2, bTerm);
      end
    end
  end
endmodule

// File: rtl/ycc_to_rgb.sv
module ycc_to_rgb
  import ycc_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [PIX_W-1:0] inY,
  input  logic             pixXOdd,
  input  logic             pixYOdd,
  input  logic             atRightEdge,
  input  logic             atBottomEdge,
  input  logic [PIX_W-1:0] cbNear,
  input  logic [PIX_W-1:0] cbRight,
  input  logic [PIX_W-1:0] cbBelow,
  input  logic [PIX_W-1:0] cbDiag,
  input  logic [PIX_W-1:0] crNear,
  input  logic [PIX_W-1:0] crRight,
  input  logic [PIX_W-1:0] crBelow,
  input  logic [PIX_W-1:0] crDiag,
  output logic             outValid,
  output logic [PIX_W-1:0] outR,
  output logic [PIX_W-1:0] outG,
  output logic [PIX_W-1:0] outB
);
  stageStrobe_t strobe;

  ycc_ctrl #(.LAT(LATENCY)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .strobe(strobe), .outValid(outValid)
  );

  ycc_datapath #(.PW(PIX_W), .FW(FRAC_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inY(inY),
    .pixXOdd(pixXOdd), .pixYOdd(pixYOdd),
    .atRightEdge(atRightEdge), .atBottomEdge(atBottomEdge),
    .cbNear(cbNear), .cbRight(cbRight), .cbBelow(cbBelow), .cbDiag(cbDiag),
    .crNear(crNear), .crRight(crRight), .crBelow(crBelow), .crDiag(crDiag),
    .outR(outR), .outG(outG), .outB(outB)
  );
endmodule

// File: rtl/ycc_to_rgb_chk.sv
module ycc_to_rgb_chk (
  input logic       clk,
  input logic       rstN,
  input logic       inValid,
  input logic [7:0] inY,
  input logic       pixXOdd,
  input logic       pixYOdd,
  input logic       atRightEdge,
  input logic       atBottomEdge,
  input logic [7:0] cbNear,
  input logic [7:0] cbRight,
  input logic [7:0] cbBelow,
  input logic [7:0] cbDiag,
  input logic [7:0] crNear,
  input logic [7:0] crRight,
  input logic [7:0] crBelow,
  input logic [7:0] crDiag,
  input logic       outValid,
  input logic [7:0] outR,
  input logic [7:0] outG,
  input logic [7:0] outB
);
  logic allNeutral;
  assign allNeutral = (cbNear == 8'd128) && (cbRight == 8'd128) && (cbBelow == 8'd128) &&
                      (cbDiag == 8'd128) && (crNear == 8'd128) && (crRight == 8'd128) &&
                      (crBelow == 8'd128) && (crDiag == 8'd128);

  p_latency_r10: assert property (@(posedge clk) disable iff (!rstN)
    inValid |-> ##3 outValid);

  p_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> $stable({outR, outG, outB}));

  p_neutral_gray_r2: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && allNeutral) |-> ##3 (outR == outG && outG == outB));

  p_even_site_r5: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !pixXOdd && !pixYOdd && cbNear == 8'd128 && crNear == 8'd128)
      |-> ##3 (outR == outG && outG == outB));
endmodule

bind ycc_to_rgb ycc_to_rgb_chk u_chk (.*);

// File: tb/ycc_to_rgb_tb.sv
module ycc_to_rgb_tb;
  localparam int NCYC = 3000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [7:0] inY = '0;
  logic pixXOdd = 1'b0, pixYOdd = 1'b0, atRightEdge = 1'b0, atBottomEdge = 1'b0;
  logic [7:0] cbNear = '0, cbRight = '0, cbBelow = '0, cbDiag = '0;
  logic [7:0] crNear = '0, crRight = '0, crBelow = '0, crDiag = '0;
  logic outValid;
  logic [7:0] outR, outG, outB;

  int nTests = 0;
  int nFail = 0;
  bit finished = 0;

  int expV[NCYC];
  int expR[NCYC];
  int expG[NCYC];
  int expB[NCYC];
  string expTag[NCYC];

  always #2 clk = ~clk;

  ycc_to_rgb u_dut (.*);

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int interp(int n, int r, int b, int d, bit xo, bit yo, bit er, bit eb);
    int rr, bb, dd;
    rr = er ? n : r;
    bb = eb ? n : b;
    dd = er ? bb : (eb ? rr : d);
    if (!xo && !yo) return n;
    if (xo && !yo)  return (n + rr + 1) / 2;
    if (!xo && yo)  return (n + bb + 1) / 2;
    return (n + rr + bb + dd + 2) / 4;
  endfunction

  function automatic int clamp8(int v);
    if (v < 0) return 0;
    if (v > 255) return 255;
    return v;
  endfunction

  task automatic setPix(input bit v, input int y, input int cbN, input int cbR, input int cbBl,
                        input int cbD, input int crN, input int crR, input int crBl, input int crD,
                        input bit xo, input bit yo, input bit er, input bit eb);
    inValid = v; inY = 8'(y);
    cbNear = 8'(cbN); cbRight = 8'(cbR); cbBelow = 8'(cbBl); cbDiag = 8'(cbD);
    crNear = 8'(crN); crRight = 8'(crR); crBelow = 8'(crBl); crDiag = 8'(crD);
    pixXOdd = xo; pixYOdd = yo; atRightEdge = er; atBottomEdge = eb;
  endtask

  task automatic record(input int cyc, input string tag);
    int cb, cr, y;
    cb = interp(cbNear, cbRight, cbBelow, cbDiag, pixXOdd, pixYOdd, atRightEdge, atBottomEdge);
    cr = interp(crNear, crRight, crBelow, crDiag, pixXOdd, pixYOdd, atRightEdge, atBottomEdge);
    y = inY;
    expV[cyc] = inValid;
    expTag[cyc] = tag;
    expR[cyc] = clamp8((y * 4096 + 5743 * (cr - 128) + 2048) >>> 12);
    expG[cyc] = clamp8((y * 4096 - 1410 * (cb - 128) - 2925 * (cr - 128) + 2048) >>> 12);
    expB[cyc] = clamp8((y * 4096 + 7258 * (cb - 128) + 2048) >>> 12);
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      nTests++; nFail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    int lastR, lastG, lastB;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(outValid == 0 && outR == 0 && outG == 0 && outB == 0, "R11 reset state",
          {outValid, outR}, 0);
    rstN = 1'b1;
    lastR = 0; lastG = 0; lastB = 0;
    for (int cyc = 0; cyc < NCYC; cyc++) begin
      @(negedge clk);
      if (cyc >= 3) begin
        int k;
        k = cyc - 3;
        check(outValid == expV[k], "R10 outValid", outValid, expV[k]);
        if (expV[k] != 0) begin
          check(outR == expR[k], {"R1 red ", expTag[k]}, outR, expR[k]);
          check(outG == expG[k], {"R2 green ", expTag[k]}, outG, expG[k]);
          check(outB == expB[k], {"R3 blue ", expTag[k]}, outB, expB[k]);
          lastR = outR; lastG = outG; lastB = outB;
        end else begin
          check(outR == lastR && outG == lastG && outB == lastB, "R11 hold while idle",
                {outR, outG, outB}, (lastR << 16) | (lastG << 8) | lastB);
        end
      end
      case (cyc)
        0:  begin setPix(1, 100, 128,9,9,9, 128,9,9,9, 0,0,0,0); record(cyc, "R5 grey even"); end
        1:  begin setPix(1, 255, 128,128,128,128, 255,255,255,255, 0,0,0,0); record(cyc, "R4 top clamp"); end
        2:  begin setPix(1, 0, 0,0,0,0, 128,128,128,128, 0,0,0,0); record(cyc, "R4 low clamp"); end
        3:  begin setPix(1, 90, 100,101,7,7, 50,60,7,7, 1,0,0,0); record(cyc, "R6 odd column"); end
        4:  begin setPix(1, 120, 10,200,20,200, 30,200,41,200, 0,1,0,0); record(cyc, "R7 odd row"); end
        5:  begin setPix(1, 80, 1,2,3,4, 200,210,220,231, 1,1,0,0); record(cyc, "R8 four way"); end
        6:  begin setPix(1, 128, 40,250,250,250, 60,250,250,250, 1,0,1,0); record(cyc, "R9 right edge"); end
        7:  begin setPix(1, 128, 40,250,250,250, 60,250,250,250, 0,1,0,1); record(cyc, "R9 bottom edge"); end
        8:  begin setPix(1, 128, 40,250,250,250, 60,250,250,250, 1,1,1,1); record(cyc, "R9 corner"); end
        9:  begin setPix(1, 128, 40,250,20,250, 60,250,80,250, 1,1,1,0); record(cyc, "R9 right diag"); end
        10: begin setPix(0, 33, 1,1,1,1, 1,1,1,1, 0,0,0,0); record(cyc, "R11 idle"); end
        11: begin setPix(1, 128, 40,20,250,250, 60,80,250,250, 1,1,0,1); record(cyc, "R9 bottom diag"); end
        default: begin
          if (cyc < NCYC - 3) begin
            setPix(($urandom % 5) != 0, $urandom % 256,
                   $urandom % 256, $urandom % 256, $urandom % 256, $urandom % 256,
                   $urandom % 256, $urandom % 256, $urandom % 256, $urandom % 256,
                   $urandom % 2, $urandom % 2, ($urandom % 10) == 0, ($urandom % 10) == 0);
            record(cyc, "random");
          end else begin
            setPix(0, 0, 0,0,0,0, 0,0,0,0, 0,0,0,0);
            record(cyc, "drain");
          end
        end
      endcase
    end
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule